// File: doc/BRIEF.md
# Indirect Table Access Controller

A management processor that only has 16-bit register access uses this block to reach a wide internal table of 1024 entries, each 64 bits. The processor fills four 16-bit staging words with a 64-bit value and writes an entry selector word. It then writes a command word, which names the direction and sets a go bit. The block performs one access on a single-port synchronous RAM that it contains, and clears the go bit when the access is complete. The processor polls that bit to find out when the access has finished.

For a write command, the staged 64-bit value is stored into the selected entry. For a read command, the selected entry is fetched and loaded into the four staging words, where the processor can then read it. A stall input from the forwarding engine holds off the RAM cycle for as long as the engine needs the table. The command and the entry index are captured at the moment the command starts. While an access is in flight, all register writes are dropped.

Top module: `entry_table_port`

## Requirements
- R1: After synchronous reset, the four staging words, the command word and the selector word all read as 0.
- R2: Register addresses 0 to 3 are the staging words. Address k holds bits 16k+15 down to 16k of the 64-bit staging value. An idle write to one of these addresses reads back unchanged.
- R3: Address 5 is the selector word. The 10-bit entry index is {word[15:8], word[1:0]}. Bits 7 to 2 are not stored and read back as 0.
- R4: Address 4 is the command word. Bit 0 selects the direction (0 = write, 1 = read) and reads back the last direction written. Bit 1 is go/busy. An idle write with bit 1 = 0 starts no access and leaves the staging words unchanged.
- R5: A write command stores the staged 64-bit value into the selected entry. Without stall, busy reads 1 for exactly one cycle after the clock edge that accepted the command.
- R6: A read command loads the selected entry into the four staging words. The data is registered one cycle after the RAM read, so without stall busy reads 1 for exactly two cycles.
- R7: While busy, writes to the staging words, the selector word and the command word have no effect.
- R8: The direction and the entry index are captured when the command is accepted. The access uses those values even if a register write is attempted later.
- R9: No RAM cycle takes place while the stall input is high. Each stalled cycle lengthens busy by one cycle, and busy clears only after the RAM cycle has happened.
- R10: Addresses 6 and 7 read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data for reg_addr (combinational) |
| eng_stall | input | 1 | Forwarding engine holds the table; access waits |

## Verification
Directed accesses at indices 0, 1, 4 and 1023 show whether the low two and the high eight index bits reach the correct entries without aliasing. Held-stall runs of fixed length separate a correct busy length from one that is off by a cycle, for both writes and reads. Register writes issued in the middle of a stalled access show whether the staging words, the selector, the direction and the index in flight are all protected. Random data at random indices, with a random stall on every cycle, then show that every entry written reads back intact however the stall interleaves.

// File: rtl/etp_pkg.sv
package etp_pkg;

    localparam int WORD_W  = 16;
    localparam int N_WORDS = 4;
    localparam int IDX_W   = 10;
    localparam int DATA_W  = WORD_W * N_WORDS;
    localparam int REG_AW  = 3;

    localparam logic [REG_AW-1:0] RA_CTRL = 3'd4;
    localparam logic [REG_AW-1:0] RA_SEL  = 3'd5;

    localparam int CB_DIR = 0;
    localparam int CB_GO  = 1;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_ACCESS,
        ST_CAPTURE
    } seq_state_t;

    typedef struct packed {
        logic             rd;
        logic [IDX_W-1:0] idx;
    } tbl_cmd_t;

    // Entry index is split across the selector word: high byte plus two low bits.
    function automatic logic [IDX_W-1:0] sel_to_idx(input logic [WORD_W-1:0] w);
        return {w[15:8], w[1:0]};
    endfunction

    function automatic logic [WORD_W-1:0] idx_to_sel(input logic [IDX_W-1:0] i);
        return {i[9:2], 6'b000000, i[1:0]};
    endfunction

endpackage

// File: rtl/etp_ram.sv
module etp_ram #(
    parameter int AW = etp_pkg::IDX_W,
    parameter int DW = etp_pkg::DATA_W
) (
    input  logic          clk,
    input  logic          en,
    input  logic          we,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] q
);
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (en) begin
            if (we) begin
                mem[addr] <= wdata;
            end else begin
                q <= mem[addr];
            end
        end
    end
endmodule

// File: rtl/etp_regs.sv
module etp_regs
    import etp_pkg::*;
#(
    parameter int NW = N_WORDS,
    parameter int WW = WORD_W
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 reg_we,
    input  logic [REG_AW-1:0]    reg_addr,
    input  logic [WW-1:0]        reg_wdata,
    output logic [WW-1:0]        reg_rdata,
    input  logic                 busy,
    input  logic                 cap_en,
    input  logic [NW*WW-1:0]     cap_data,
    output logic [NW*WW-1:0]     stage_data,
    output logic                 trig,
    output tbl_cmd_t             cmd
);
    localparam int WS = $clog2(NW);

    logic [NW-1:0][WW-1:0] word_q;
    logic [IDX_W-1:0]      sel_q;
    logic                  dir_q;
    logic                  wr_ok;

    assign wr_ok      = reg_we && !busy;
    assign trig       = wr_ok && (reg_addr == RA_CTRL) && reg_wdata[CB_GO];
    assign cmd.rd     = reg_wdata[CB_DIR];
    assign cmd.idx    = sel_q;
    assign stage_data = word_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            word_q <= '0;
            sel_q  <= '0;
            dir_q  <= 1'b0;
        end else begin
            if (cap_en) begin
                word_q <= cap_data;
            end else if (wr_ok) begin
                for (int k = 0; k < NW; k++) begin
                    if (reg_addr == REG_AW'(k)) begin
                        word_q[k] <= reg_wdata;
                    end
                end
            end
            if (wr_ok && reg_addr == RA_SEL) begin
                sel_q <= sel_to_idx(reg_wdata);
            end
            if (wr_ok && reg_addr == RA_CTRL) begin
                dir_q <= reg_wdata[CB_DIR];
            end
        end
    end

    always_comb begin
        reg_rdata = '0;
        if (reg_addr < REG_AW'(NW)) begin
            reg_rdata = word_q[reg_addr[WS-1:0]];
        end else if (reg_addr == RA_CTRL) begin
            reg_rdata = {{(WW-2){1'b0}}, busy, dir_q};
        end else if (reg_addr == RA_SEL) begin
            reg_rdata = idx_to_sel(sel_q);
        end
    end

    // R7: staging words only change through the capture path while busy
    a_r7_words_frozen: assert property (@(posedge clk) disable iff (rst)
        (busy && !cap_en) |=> $stable(word_q));

    // R7: selector word cannot be rewritten during an access
    a_r7_sel_frozen: assert property (@(posedge clk) disable iff (rst)
        busy |=> $stable(sel_q));

endmodule

// File: rtl/etp_seq.sv
module etp_seq
    import etp_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             trig,
    input  tbl_cmd_t         cmd,
    input  logic             stall,
    output logic             busy,
    output logic             ram_en,
    output logic             ram_we,
    output logic [IDX_W-1:0] ram_idx,
    output logic             cap_en
);
    seq_state_t state_q;
    tbl_cmd_t   cmd_q;

    assign busy    = (state_q != ST_IDLE);
    assign ram_en  = (state_q == ST_ACCESS) && !stall;
    assign ram_we  = ram_en && !cmd_q.rd;
    assign ram_idx = cmd_q.idx;
    assign cap_en  = (state_q == ST_CAPTURE);

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            cmd_q   <= '0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (trig) begin
                        cmd_q   <= cmd;
                        state_q <= ST_ACCESS;
                    end
                end
                ST_ACCESS: begin
                    if (!stall) begin
                        state_q <= cmd_q.rd ? ST_CAPTURE : ST_IDLE;
                    end
                end
                ST_CAPTURE: state_q <= ST_IDLE;
                default:    state_q <= ST_IDLE;
            endcase
        end
    end

    // R9: a stalled access stays pending
    a_r9_stall_holds: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_ACCESS && stall) |=> (state_q == ST_ACCESS));

    // R6: capture only follows an actual RAM read
    a_r6_capture_after_read: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_CAPTURE) |-> $past(ram_en && !ram_we));

    // R5: a RAM write finishes the command on the next edge
    a_r5_write_completes: assert property (@(posedge clk) disable iff (rst)
        (ram_en && ram_we) |=> !busy);

    // R8: captured command does not move during an access
    a_r8_cmd_held: assert property (@(posedge clk) disable iff (rst)
        busy |=> $stable(cmd_q));

endmodule

// File: rtl/entry_table_port.sv
module entry_table_port
    import etp_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_we,
    input  logic [REG_AW-1:0] reg_addr,
    input  logic [WORD_W-1:0] reg_wdata,
    output logic [WORD_W-1:0] reg_rdata,
    input  logic              eng_stall
);
    logic             busy;
    logic             cap_en;
    logic             trig;
    tbl_cmd_t         cmd;
    logic [DATA_W-1:0] stage_data;
    logic [DATA_W-1:0] ram_q;
    logic             ram_en;
    logic             ram_we;
    logic [IDX_W-1:0] ram_idx;

    etp_regs #(.NW(N_WORDS), .WW(WORD_W)) u_regs (
        .clk        (clk),
        .rst        (rst),
        .reg_we     (reg_we),
        .reg_addr   (reg_addr),
        .reg_wdata  (reg_wdata),
        .reg_rdata  (reg_rdata),
        .busy       (busy),
        .cap_en     (cap_en),
        .cap_data   (ram_q),
        .stage_data (stage_data),
        .trig       (trig),
        .cmd        (cmd)
    );

    etp_seq u_seq (
        .clk     (clk),
        .rst     (rst),
        .trig    (trig),
        .cmd     (cmd),
        .stall   (eng_stall),
        .busy    (busy),
        .ram_en  (ram_en),
        .ram_we  (ram_we),
        .ram_idx (ram_idx),
        .cap_en  (cap_en)
    );

    etp_ram #(.AW(IDX_W), .DW(DATA_W)) u_ram (
        .clk   (clk),
        .en    (ram_en),
        .we    (ram_we),
        .addr  (ram_idx),
        .wdata (stage_data),
        .q     (ram_q)
    );

    // R9: the table is never touched while the engine stalls
    a_r9_no_access_in_stall: assert property (@(posedge clk) disable iff (rst)
        eng_stall |-> !ram_en);

endmodule

// File: tb/entry_table_port_bench.sv
module entry_table_port_bench;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_we = 1'b0;
    logic [2:0]  reg_addr = '0;
    logic [15:0] reg_wdata = '0;
    logic [15:0] reg_rdata;
    logic        eng_stall = 1'b0;

    int checks = 0;
    int errors = 0;
    bit done = 0;
    bit rand_stall = 0;
    int stall_left = 0;

    logic [63:0] model [1024];
    int          wr_list [48];

    always #10 clk = ~clk;

    entry_table_port u_entry_table_port (
        .clk       (clk),
        .rst       (rst),
        .reg_we    (reg_we),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .eng_stall (eng_stall)
    );

    function automatic logic [15:0] f_sel(int idx);
        logic [9:0] i;
        i = 10'(idx);
        return {i[9:2], 6'b0, i[1:0]};
    endfunction

    function automatic logic [15:0] f_sel_back(logic [15:0] w);
        return w & 16'hFF03;
    endfunction

    task automatic check(string req, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic reg_wr(logic [2:0] a, logic [15:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic reg_rd(logic [2:0] a, output logic [15:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic stage(logic [63:0] d);
        for (int k = 0; k < 4; k++) reg_wr(3'(k), d[16*k +: 16]);
    endtask

    task automatic read_stage(output logic [63:0] d);
        logic [15:0] w;
        for (int k = 0; k < 4; k++) begin
            reg_rd(3'(k), w);
            d[16*k +: 16] = w;
        end
    endtask

    task automatic poll(output int cnt);
        cnt = 0;
        reg_addr = 3'd4;
        #1;
        while (reg_rdata[1]) begin
            cnt++;
            if (stall_left > 0) stall_left--;
            eng_stall = rand_stall ? ($urandom % 3 == 0) : (stall_left > 0);
            @(negedge clk);
            #1;
        end
        eng_stall = 1'b0;
    endtask

    task automatic access(bit rd, int idx, int k, output int cnt);
        reg_wr(3'd5, f_sel(idx));
        stall_left = (k > 0) ? k + 1 : 0;
        if (!rand_stall) eng_stall = (k > 0);
        reg_wr(3'd4, {14'b0, 1'b1, rd});
        poll(cnt);
    endtask

    task automatic read_entry(int idx, output logic [63:0] d);
        int c;
        access(1'b1, idx, 0, c);
        read_stage(d);
    endtask

    initial begin
        logic [15:0] w;
        logic [63:0] d;
        int cnt;
        void'($urandom(32'd20240));

        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 / R10 reset state and unused addresses
        for (int a = 0; a < 8; a++) begin
            reg_rd(3'(a), w);
            check((a < 6) ? "R1 reset value" : "R10 unused address", w, 16'h0);
        end

        // R2 staging words
        stage(64'h0123_4567_89AB_CDEF);
        read_stage(d);
        check("R2 staging readback", d, 64'h0123_4567_89AB_CDEF);

        // R3 selector layout
        reg_wr(3'd5, 16'hFFFF);
        reg_rd(3'd5, w);
        check("R3 selector bits", w, f_sel_back(16'hFFFF));
        reg_wr(3'd5, 16'h00FC);
        reg_rd(3'd5, w);
        check("R3 unused selector bits", w, 16'h0000);

        // R5 writes at boundary and split-field indices
        stage(64'hAAAA_0000_1111_0001); access(1'b0, 0, 0, cnt);
        model[0] = 64'hAAAA_0000_1111_0001;
        check("R5 write busy length", 64'(cnt), 64'd1);
        stage(64'hBBBB_2222_3333_03FF); access(1'b0, 1023, 0, cnt);
        model[1023] = 64'hBBBB_2222_3333_03FF;
        check("R5 write busy length idx 1023", 64'(cnt), 64'd1);
        stage(64'hCCCC_4444_5555_0001); access(1'b0, 1, 0, cnt);
        model[1] = 64'hCCCC_4444_5555_0001;
        stage(64'hDDDD_6666_7777_0004); access(1'b0, 4, 0, cnt);
        model[4] = 64'hDDDD_6666_7777_0004;

        // R6 reads
        stage(64'h0); access(1'b1, 0, 0, cnt);
        check("R6 read busy length", 64'(cnt), 64'd2);
        read_stage(d);
        check("R6 read idx 0", d, model[0]);
        read_entry(1023, d); check("R6 read idx 1023", d, model[1023]);
        read_entry(1, d);    check("R6 read idx 1 (low field)", d, model[1]);
        read_entry(4, d);    check("R6 read idx 4 (high field)", d, model[4]);

        // R4 command without go
        stage(64'hEEEE_EEEE_EEEE_EEEE);
        reg_wr(3'd4, 16'h0001);
        reg_rd(3'd4, w);
        check("R4 dir readback, no busy", w, 16'h0001);
        repeat (3) @(negedge clk);
        read_stage(d);
        check("R4 no access started", d, 64'hEEEE_EEEE_EEEE_EEEE);

        // R9 held stall
        stage(64'hF00D_F00D_0000_0005); access(1'b0, 5, 5, cnt);
        model[5] = 64'hF00D_F00D_0000_0005;
        check("R9 stalled write busy length", 64'(cnt), 64'd6);
        stage(64'h0); access(1'b1, 5, 3, cnt);
        check("R9 stalled read busy length", 64'(cnt), 64'd5);
        read_stage(d);
        check("R9 stalled read data", d, model[5]);

        // R7 / R8 writes during a stalled access
        stage(64'h1234_5678_9ABC_0009);
        reg_wr(3'd5, f_sel(9));
        eng_stall = 1'b1;
        reg_wr(3'd4, 16'h0002);
        reg_wr(3'd0, 16'hDEAD);
        reg_wr(3'd5, f_sel(0));
        reg_wr(3'd4, 16'h0003);
        reg_rd(3'd4, w);
        check("R7 command write ignored while busy", w, 16'h0002);
        stall_left = 0;
        eng_stall = 1'b0;
        poll(cnt);
        model[9] = 64'h1234_5678_9ABC_0009;
        read_stage(d);
        check("R7 staging write ignored", d, 64'h1234_5678_9ABC_0009);
        reg_rd(3'd5, w);
        check("R7 selector write ignored", w, f_sel(9));
        read_entry(0, d); check("R8 other entry untouched", d, model[0]);
        read_entry(9, d); check("R8 latched index written", d, model[9]);

        // Random writes and reads under random stall (R5, R6, R9)
        rand_stall = 1;
        for (int n = 0; n < 48; n++) begin
            int idx;
            logic [63:0] v;
            idx = int'($urandom % 1024);
            v = {$urandom, $urandom};
            stage(v);
            access(1'b0, idx, 0, cnt);
            model[idx] = v;
            wr_list[n] = idx;
        end
        for (int n = 0; n < 48; n++) begin
            int idx;
            idx = wr_list[$urandom % 48];
            read_entry(idx, d);
            check("R6 R9 random readback", d, model[idx]);
        end
        rand_stall = 0;

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired actual=hung expected=done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule